// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block receives command frames for a two-grid fluorescent display controller over a three-wire serial link. The link has a frame-enable line, a serial clock and one bidirectional data line. While the frame-enable line is high, each rising edge of the serial clock moves one data bit into a 64-bit frame register. Nothing takes effect until the frame-enable line falls. At that point a 4-bit command code is pulled from the frame and acted on. The command can update the 60 display latch bits, switch the brightness source between the analog and digital paths, or load the 11-bit digital brightness value. It can also arm a readout of the 30 key-matrix bits and raise a key-scan stop request toward the scanning block.

All pins are first brought into the system clock domain through a two-stage synchronizer and edge detector, so the block runs on one clock. Frames of exactly 64 bits, or longer, carry the command code at a fixed position inside the frame. Shorter frames carry the command code in the last four bits sent, with the payload sent just before it. During a key readout the block drives the data line, and the frame-enable falling edge that ends the readout returns it to receiving.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset the display latches are all zero, the brightness source is analog (`dim_digital_o`=0), the brightness value is zero, the data line is not driven and no stop request is raised.
- R2: Bits enter the frame register only on a rising serial clock while the frame-enable line is high. The registered outputs change only in response to a frame-enable falling edge. Serial clocks while frame-enable is low have no effect.
- R3: A frame of 64 or more bits uses its last 64 bits. The first-sent bit is frame bit 63, and the command code is frame bits 51:48 (first-sent bit of the code is the MSB). For a display command the latches load {frame[63:52], frame[47:0]}, so the first bit sent lands in `disp_o[59]` and the last in `disp_o[0]`.
- R4: The command codes are display 0000, brightness-data 0001, display+analog 0010, analog 0011, display+digital 0100, digital 0101, display+readout 0110, readout 0111, readout+stop 1000 and stop 1001. Codes 0010 and 0011 set `dim_digital_o` to 0. Codes 0100, 0101 and 0001 set it to 1.
- R5: Code 0001 loads the 11-bit brightness value. In a full frame the value comes from frame[62:52]. In a short frame it comes from the 11 bits sent just before the code, with missing bits read as zero.
- R6: Codes 1010 to 1111 change nothing. A frame of fewer than 4 bits changes nothing. A short frame that carries a display command (0000, 0010, 0100, 0110) is dropped whole.
- R7: Codes 0110, 0111 and 1000 capture `key_data_i` at the falling edge and drive the data line. `sdio_o` shows bit 0 first and advances one bit per rising serial clock. After the 30 bits it shows 0.
- R8: The next frame-enable falling edge releases the data line. The frame clocked during the readout is not decoded.
- R9: Codes 1000 and 1001 raise `stop_req_o`, which stays high until `stop_ack_i` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Frame-enable line, high during a frame |
| sclk_i | input | 1 | Serial clock, bit taken on its rising edge |
| sdio_i | input | 1 | Serial data from the pad |
| key_data_i | input | 30 | Key-matrix bits, bit 0 read out first |
| stop_ack_i | input | 1 | Scanning block acknowledges a stop request |
| sdio_o | output | 1 | Serial readout data to the pad |
| sdio_oe_o | output | 1 | Drive enable for the data pad |
| disp_o | output | 60 | Display latch contents |
| dim_digital_o | output | 1 | Brightness source: 1 digital, 0 analog |
| dim_value_o | output | 11 | Digital brightness value |
| stop_req_o | output | 1 | Key-scan stop request |

## Verification
The in-line assertions check properties that hold on every cycle. The frame register and all decoded outputs stay frozen unless a bit is shifted in or a frame ends. The bit counter never goes past the frame length. The drive enable switches on only at a readout start and off only at a frame end. A stop request persists until it is acknowledged. Only the bench scenarios can show the payload bit mapping, the choice between the full-frame and short-frame code positions, that reserved or truncated frames leave state untouched, and that the readout bit order is right and ends in zeros.

// File: rtl/cfr_pkg.sv
// Shared constants, command codes and the command-to-action decode for the
// serial command frame receiver. Assumes a 4-bit command field.
package cfr_pkg;

    localparam int CMD_W  = 4;
    localparam int PIN_CS = 0;
    localparam int PIN_CK = 1;
    localparam int PIN_DI = 2;
    localparam int PIN_N  = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_DISP         = 4'b0000,
        CMD_DIM_DATA     = 4'b0001,
        CMD_DISP_ANA     = 4'b0010,
        CMD_SEL_ANA      = 4'b0011,
        CMD_DISP_DIG     = 4'b0100,
        CMD_SEL_DIG      = 4'b0101,
        CMD_DISP_KEY     = 4'b0110,
        CMD_KEY_OUT      = 4'b0111,
        CMD_KEY_OUT_STOP = 4'b1000,
        CMD_KEY_STOP     = 4'b1001
    } cmd_e;

    typedef struct packed {
        logic upd_disp;
        logic set_ana;
        logic set_dig;
        logic load_dim;
        logic key_out;
        logic key_stop;
    } act_t;

    // Translate a command code into the effects it has; display-carrying
    // codes are void unless the frame was a full one.
    function automatic act_t cmd_actions(input logic [CMD_W-1:0] code, input logic full);
        act_t a;
        a = '0;
        case (code)
            CMD_DISP:         a.upd_disp = full;
            CMD_DIM_DATA:     begin a.load_dim = 1'b1; a.set_dig = 1'b1; end
            CMD_DISP_ANA:     begin a.upd_disp = full; a.set_ana = full; end
            CMD_SEL_ANA:      a.set_ana = 1'b1;
            CMD_DISP_DIG:     begin a.upd_disp = full; a.set_dig = full; end
            CMD_SEL_DIG:      a.set_dig = 1'b1;
            CMD_DISP_KEY:     begin a.upd_disp = full; a.key_out = full; end
            CMD_KEY_OUT:      a.key_out = 1'b1;
            CMD_KEY_OUT_STOP: begin a.key_out = 1'b1; a.key_stop = 1'b1; end
            CMD_KEY_STOP:     a.key_stop = 1'b1;
            default:          a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cfr_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins, plus one extra
// register of the synchronized value so the parent can detect edges.
// Assumes each pin is quasi-static for several system clocks.
module cfr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_prev_o
);

    logic [W-1:0] stage [STAGES];
    logic [W-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= d_i;
            end
        end else begin : g_next
            // Pass along the resolver chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    // Hold last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage[STAGES-1];
    end

    assign q_o      = stage[STAGES-1];
    assign q_prev_o = prev_q;

endmodule

// File: rtl/cfr_shifter.sv
// Frame register: shifts in one bit per enable, newest bit at index 0, and
// counts received bits saturating at the frame length. Cleared at frame start
// so bits not sent in a short frame read as zero.
module cfr_shifter #(
    parameter int FRAME_W = 64,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  logic               shift_en_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] sr_o,
    output logic [CNT_W-1:0]   cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;

    // Shift data and track frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start_i) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en_i) begin
            sr_q <= {sr_q[FRAME_W-2:0], bit_i};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sr_o  = sr_q;
    assign cnt_o = cnt_q;

    // R2
    sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en_i && !frame_start_i) |=> $stable(sr_q));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

endmodule

// File: rtl/cfr_decoder.sv
// Command decoder: at frame end picks the command code from the full-frame
// or short-frame position, applies its effects to the display latches,
// brightness source and value, starts a readout and raises a stop request.
// Assumes the readout block reports when the data line is driven (busy_i).
module cfr_decoder
    import cfr_pkg::*;
#(
    parameter int FRAME_W = 64,
    parameter int CODE_LSB = 48,
    parameter int DIM_W    = 11,
    localparam int CNT_W   = $clog2(FRAME_W + 1),
    localparam int DISP_W  = FRAME_W - CMD_W,
    localparam int PAY_LSB = CODE_LSB + CMD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] sr_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               frame_end_i,
    input  logic               busy_i,
    input  logic               stop_ack_i,
    output logic               key_start_o,
    output logic [DISP_W-1:0]  disp_o,
    output logic               dim_digital_o,
    output logic [DIM_W-1:0]   dim_value_o,
    output logic               stop_req_o
);

    logic              full;
    logic              valid;
    logic              apply;
    logic [CMD_W-1:0]  code;
    logic [DIM_W-1:0]  dim_pick;
    logic [DISP_W-1:0] disp_pick;
    act_t              act;

    logic [DISP_W-1:0] disp_q;
    logic              dig_q;
    logic [DIM_W-1:0]  dim_q;
    logic              stop_q;

    // Choose field positions from the received frame length.
    always_comb begin
        full      = (cnt_i == CNT_W'(FRAME_W));
        valid     = (cnt_i >= CNT_W'(CMD_W));
        code      = full ? sr_i[CODE_LSB +: CMD_W] : sr_i[CMD_W-1:0];
        dim_pick  = full ? sr_i[PAY_LSB +: DIM_W] : sr_i[CMD_W +: DIM_W];
        disp_pick = {sr_i[FRAME_W-1:PAY_LSB], sr_i[CODE_LSB-1:0]};
        apply     = frame_end_i && !busy_i && valid;
        act       = apply ? cmd_actions(code, full) : '0;
    end

    // Apply the decoded command to the held state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q <= '0;
            dig_q  <= 1'b0;
            dim_q  <= '0;
        end else begin
            if (act.upd_disp) disp_q <= disp_pick;
            if (act.set_ana)  dig_q  <= 1'b0;
            if (act.set_dig)  dig_q  <= 1'b1;
            if (act.load_dim) dim_q  <= dim_pick;
        end
    end

    // Stop request held until the scanning block acknowledges it.
    always_ff @(posedge clk) begin
        if (!rst_n)             stop_q <= 1'b0;
        else if (act.key_stop)  stop_q <= 1'b1;
        else if (stop_ack_i)    stop_q <= 1'b0;
    end

    assign key_start_o   = act.key_out;
    assign disp_o        = disp_q;
    assign dim_digital_o = dig_q;
    assign dim_value_o   = dim_q;
    assign stop_req_o    = stop_q;

    // R2
    state_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> ($stable(disp_q) && $stable(dig_q) && $stable(dim_q)));

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !stop_ack_i) |=> stop_q);

endmodule

// File: rtl/cfr_readout.sv
// Key readout: loads the key-matrix bits on a start pulse, drives the data
// line and presents one bit per serial clock, bit 0 first, zeros after the
// last bit. Releases the line at the next frame end.
module cfr_readout #(
    parameter int KEY_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             advance_i,
    input  logic             frame_end_i,
    output logic             busy_o,
    output logic             sdo_o
);

    logic [KEY_W-1:0] sh_q;
    logic             oe_q;

    // Load, step and release the readout register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (start_i) begin
            sh_q <= key_i;
            oe_q <= 1'b1;
        end else if (oe_q && frame_end_i) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (oe_q && advance_i) begin
            sh_q <= {1'b0, sh_q[KEY_W-1:1]};
        end
    end

    assign busy_o = oe_q;
    assign sdo_o  = oe_q & sh_q[0];

    // R7
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(start_i));

    // R8
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_q) |-> $past(frame_end_i));

endmodule

// File: rtl/cmd_frame_rx.sv
// Top of the serial command frame receiver. Synchronizes the pins, detects
// frame-enable and serial clock edges, and ties together the frame register,
// command decoder and key readout. Assumes the serial clock runs well below
// the system clock so every level lasts several system cycles.
module cmd_frame_rx
    import cfr_pkg::*;
#(
    parameter int FRAME_W  = 64,
    parameter int CODE_LSB = 48,
    parameter int DIM_W    = 11,
    parameter int KEY_W    = 30,
    parameter int SYNC_N   = 2,
    localparam int DISP_W  = FRAME_W - CMD_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    input  logic [KEY_W-1:0]  key_data_i,
    input  logic              stop_ack_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    output logic [DISP_W-1:0] disp_o,
    output logic              dim_digital_o,
    output logic [DIM_W-1:0]  dim_value_o,
    output logic              stop_req_o
);

    logic [PIN_N-1:0]   pins;
    logic [PIN_N-1:0]   pin_q;
    logic [PIN_N-1:0]   pin_prev;
    logic               cs_hi, cs_rise, cs_fall, ck_rise;
    logic               busy, shift_en, key_start;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;

    always_comb begin
        pins         = '0;
        pins[PIN_CS] = cs_i;
        pins[PIN_CK] = sclk_i;
        pins[PIN_DI] = sdio_i;
    end

    cfr_sync #(.W(PIN_N), .STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_i      (pins),
        .q_o      (pin_q),
        .q_prev_o (pin_prev)
    );

    // Edge events in the system clock domain.
    always_comb begin
        cs_hi    = pin_q[PIN_CS];
        cs_rise  = pin_q[PIN_CS] & ~pin_prev[PIN_CS];
        cs_fall  = ~pin_q[PIN_CS] & pin_prev[PIN_CS];
        ck_rise  = pin_q[PIN_CK] & ~pin_prev[PIN_CK];
        shift_en = cs_hi & ck_rise & ~busy;
    end

    cfr_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (cs_rise),
        .shift_en_i    (shift_en),
        .bit_i         (pin_q[PIN_DI]),
        .sr_o          (sr),
        .cnt_o         (cnt)
    );

    cfr_decoder #(.FRAME_W(FRAME_W), .CODE_LSB(CODE_LSB), .DIM_W(DIM_W)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .sr_i          (sr),
        .cnt_i         (cnt),
        .frame_end_i   (cs_fall),
        .busy_i        (busy),
        .stop_ack_i    (stop_ack_i),
        .key_start_o   (key_start),
        .disp_o        (disp_o),
        .dim_digital_o (dim_digital_o),
        .dim_value_o   (dim_value_o),
        .stop_req_o    (stop_req_o)
    );

    cfr_readout #(.KEY_W(KEY_W)) u_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (key_start),
        .key_i       (key_data_i),
        .advance_i   (cs_hi & ck_rise),
        .frame_end_i (cs_fall),
        .busy_o      (busy),
        .sdo_o       (sdio_o)
    );

    assign sdio_oe_o = busy;

endmodule

// File: tb/sim_cmd_frame_rx.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks send frames and push the expected state;
// a monitor pops and compares once the frame has taken effect.
module sim_cmd_frame_rx;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_i = 1'b0, sclk_i = 1'b0, sdio_i = 1'b0, stop_ack_i = 1'b0;
    logic [29:0] key_data_i = '0;
    logic        sdio_o, sdio_oe_o, dim_digital_o, stop_req_o;
    logic [59:0] disp_o;
    logic [10:0] dim_value_o;

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct packed {
        logic [59:0] disp;
        logic        dig;
        logic [10:0] dim;
        logic        oe;
        logic        stop;
    } exp_t;

    exp_t  mdl;
    exp_t  exp_q[$];
    string tag_q[$];
    event  chk_ev;

    always #2 clk = ~clk;

    cmd_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
        .key_data_i(key_data_i), .stop_ack_i(stop_ack_i), .sdio_o(sdio_o),
        .sdio_oe_o(sdio_oe_o), .disp_o(disp_o), .dim_digital_o(dim_digital_o),
        .dim_value_o(dim_value_o), .stop_req_o(stop_req_o)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    // Monitor: pop one expectation per event and compare every output.
    initial begin
        forever begin
            @(chk_ev);
            begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(disp_o === e.disp, {t, " disp"}, 64'(disp_o), 64'(e.disp));
                chk(dim_digital_o === e.dig, {t, " dig"}, 64'(dim_digital_o), 64'(e.dig));
                chk(dim_value_o === e.dim, {t, " dim"}, 64'(dim_value_o), 64'(e.dim));
                chk(sdio_oe_o === e.oe, {t, " oe"}, 64'(sdio_oe_o), 64'(e.oe));
                chk(stop_req_o === e.stop, {t, " stop"}, 64'(stop_req_o), 64'(e.stop));
            end
        end
    end

    task automatic expect_now(input string t);
        exp_q.push_back(mdl);
        tag_q.push_back(t);
        -> chk_ev;
        @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        sdio_i = b; sclk_i = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk_i = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    // Send a frame: pre junk bits first, then n bits from bits[n-1] down to bits[0].
    task automatic send(input logic [63:0] bits, input int n, input int pre);
        cs_i = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < pre; i++) clk_bit(i[0]);
        for (int i = n - 1; i >= 0; i--) clk_bit(bits[i]);
        sclk_i = 1'b0;
        repeat (4) @(negedge clk);
        cs_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [63:0] full_fr(input logic [59:0] d, input logic [3:0] m);
        return {d[59:48], m, d[47:0]};
    endfunction

    // Read the key bits during a frame and check each, then end the frame.
    task automatic read_keys(input logic [29:0] k, input string t);
        cs_i = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            sdio_i = ~i[0]; sclk_i = 1'b0;
            repeat (HALF) @(negedge clk);
            chk(sdio_o === ((i < 30) ? k[i] : 1'b0), t, 64'(sdio_o), 64'((i < 30) ? k[i] : 1'b0));
            sclk_i = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sclk_i = 1'b0;
        repeat (4) @(negedge clk);
        cs_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic ack_stop();
        stop_ack_i = 1'b1;
        repeat (2) @(negedge clk);
        stop_ack_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [59:0] pa, pb, pc, pd, pe;
        mdl = '0;
        pa = 60'hA5C_3F0F_1234_5678;
        pb = 60'h123_4567_89AB_CDEF;
        pc = 60'hFED_CBA9_8765_4321;
        pd = 60'h0F0_F0F0_F0F0_F0F1;
        pe = 60'h800_0000_0000_0001;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_now("R1 reset");

        // R3 full display frame, first bit lands in disp[59]
        send(full_fr(pa, 4'b0000), 64, 0);
        mdl.disp = pa;
        expect_now("R3 display");

        // R2 serial clocks with frame-enable low change nothing
        for (int i = 0; i < 10; i++) clk_bit(1'b1);
        repeat (10) @(negedge clk);
        expect_now("R2 idle clocks");

        // R4 display+digital
        send(full_fr(pb, 4'b0100), 64, 0);
        mdl.disp = pb; mdl.dig = 1'b1;
        expect_now("R4 disp+dig");

        // R4 display+analog
        send(full_fr(pc, 4'b0010), 64, 0);
        mdl.disp = pc; mdl.dig = 1'b0;
        expect_now("R4 disp+ana");

        // R5 full brightness frame, value from frame[62:52]
        send({1'b1, 11'h5A3, 4'b0001, 48'hFFFF_FFFF_FFFF}, 64, 0);
        mdl.dim = 11'h5A3; mdl.dig = 1'b1;
        expect_now("R5 dim full");

        // R4 short analog select
        send({12'h000, 4'b0011}, 16, 0);
        mdl.dig = 1'b0;
        expect_now("R4 ana short");

        // R5 short brightness frame
        send({1'b0, 11'h7FE, 4'b0001}, 16, 0);
        mdl.dim = 11'h7FE; mdl.dig = 1'b1;
        expect_now("R5 dim short");

        // R5 short brightness frame with missing high bits read as zero
        send({4'hB, 4'b0001}, 8, 0);
        mdl.dim = 11'h00B;
        expect_now("R5 dim partial");

        // R6 reserved codes, full and short
        send(full_fr(pd, 4'b1111), 64, 0);
        expect_now("R6 reserved full");
        send({12'hFFF, 4'b1010}, 16, 0);
        expect_now("R6 reserved short");

        // R6 short display frame dropped; R6 frame below four bits dropped
        send({12'hABC, 4'b0010}, 16, 0);
        expect_now("R6 short display");
        send(64'b011, 3, 0);
        expect_now("R6 tiny frame");

        // R3 overlong frame keeps its last 64 bits
        send(full_fr(pd, 4'b0000), 64, 7);
        mdl.disp = pd;
        expect_now("R3 long frame");

        // R7 display+readout, R8 release and no decode of readout frame
        key_data_i = 30'h2A5F_0C93;
        send(full_fr(pe, 4'b0110), 64, 0);
        mdl.disp = pe; mdl.oe = 1'b1;
        expect_now("R7 disp+key");
        key_data_i = '0;
        read_keys(30'h2A5F_0C93, "R7 bit");
        mdl.oe = 1'b0;
        expect_now("R8 release");

        // R7 readout+stop, R9 request held then acknowledged
        key_data_i = 30'h1000_0001;
        send(64'h0000_0000_0000_0008, 16, 0);
        mdl.oe = 1'b1; mdl.stop = 1'b1;
        expect_now("R9 key+stop");
        read_keys(30'h1000_0001, "R7 bit2");
        mdl.oe = 1'b0;
        expect_now("R9 held");
        ack_stop();
        mdl.stop = 1'b0;
        expect_now("R9 ack");

        // R9 stop only
        send(64'h9, 4, 0);
        mdl.stop = 1'b1;
        expect_now("R9 stop");
        ack_stop();
        mdl.stop = 1'b0;
        expect_now("R9 ack2");

        // R7 plain readout
        key_data_i = 30'h3FFF_FFFF;
        send(64'h7, 4, 0);
        mdl.oe = 1'b1;
        expect_now("R7 key out");
        read_keys(30'h3FFF_FFFF, "R7 bit3");
        mdl.oe = 1'b0;
        expect_now("R8 release2");

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule